// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host reach a small on-chip packet memory through a single data port, one byte or one 16-bit word at a time. The host first programs a 16-bit current address, a 16-bit remaining byte count and a pair of ring page limits through a byte-wide register interface. It then issues a read or write command and strobes the data port repeatedly. Each port access moves data at the current address and steps the address forward, wrapping at the ring limit. It also counts down the bytes still owed and raises a completion flag in an interrupt status register once the count runs out.

An interrupt mask selects which status flags drive the interrupt output. Status flags are cleared by writing ones. A read or write command issued while the count is already zero completes at once. Port writes that arrive after the count is exhausted are dropped.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the status register reads 0x80, the address, count, mask and configuration registers read 0, the read data output is 0 and the interrupt output is low.
- R2: Register offsets: 0 command, 1 ring start page, 2 ring stop page, 3 address low byte, 4 address high byte, 5 count low byte, 6 count high byte, 7 status, 8 mask, 9 configuration. The 16-bit address and count are each assembled from separate low and high byte writes and read back through the same offsets. Unused offsets read 0.
- R3: With configuration bit 0 clear, each port access moves one byte at the current address. A read returns it in bits 7:0 with bits 15:8 zero. The address then advances by 1 and the count drops by 1.
- R4: With configuration bit 0 set, each port access moves a 16-bit word at the address with bit 0 forced to 0. The lower address holds bits 7:0. The address then advances by 2 from its unforced value and the count drops by 2.
- R5: When the advanced address equals the ring stop page times 256, it is replaced by the ring start page times 256.
- R6: When a port access finds the count less than or equal to the access size, the count becomes 0 and status bit 6 (transfer complete) is set.
- R7: A port write while the count is 0 changes neither memory, nor the address, nor the count.
- R8: A command write with bit 0 clear clears status bit 7. If the same write has bit 3 (read) or bit 4 (write) set while the count is 0, it sets status bit 6 at once. A nonzero count leaves bit 6 untouched.
- R9: The interrupt output is high exactly when status AND mask AND 0x7F is nonzero, so status bit 7 never raises it.
- R10: Writing the status register clears each of bits 6:0 where the written value has a 1. Bit 7 is unaffected.
- R11: Memory occupies byte addresses from the window base up to but excluding base plus window size. A byte read outside returns 0x00FF, a word read outside returns 0xFFFF, and writes outside store nothing.
- R12: Port read data is registered: it appears on the read data output after the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset for writes and for the read mux |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr (combinational) |
| portRd | input | 1 | Data port read strobe |
| portWr | input | 1 | Data port write strobe |
| portWdata | input | 16 | Data port write data |
| portRdata | output | 16 | Registered data port read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps the default parameters: a 512-byte window based at 0x0400. That makes ring pages 4 and 5 the whole memory, so a stop page of 6 puts the wrap point exactly at the window's end. With an odd address in word mode, a single step then lands at 0x0601, beyond the window and past the stop address, so the all-ones read path is reached without wrapping. Addresses below 0x0400 give a second out-of-window region for byte reads.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W = 16;
  localparam int PG_W   = ADDR_W - 8;

  localparam logic [3:0] OFS_CMD    = 4'd0;
  localparam logic [3:0] OFS_START  = 4'd1;
  localparam logic [3:0] OFS_STOP   = 4'd2;
  localparam logic [3:0] OFS_ADDRLO = 4'd3;
  localparam logic [3:0] OFS_ADDRHI = 4'd4;
  localparam logic [3:0] OFS_CNTLO  = 4'd5;
  localparam logic [3:0] OFS_CNTHI  = 4'd6;
  localparam logic [3:0] OFS_STAT   = 4'd7;
  localparam logic [3:0] OFS_MASK   = 4'd8;
  localparam logic [3:0] OFS_CFG    = 4'd9;

  localparam int STAT_DONE = 6;
  localparam int STAT_RST  = 7;

  typedef struct packed {
    logic ldStart;
    logic ldStop;
    logic ldAddrLo;
    logic ldAddrHi;
    logic ldCntLo;
    logic ldCntHi;
    logic step;
    logic rd;
    logic memWr;
    logic wide;
  } rdma_strobe_t;
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWdata,
  input  logic              portRd,
  input  logic              portWr,
  input  logic              cntZero,
  input  logic              lastStep,
  input  logic [ADDR_W-1:0] addrQ,
  input  logic [ADDR_W-1:0] cntQ,
  input  logic [PG_W-1:0]   startPg,
  input  logic [PG_W-1:0]   stopPg,
  output rdma_strobe_t      strb,
  output logic [7:0]        regRdata,
  output logic [7:0]        statusQ,
  output logic [7:0]        maskQ,
  output logic              irq
);
  logic [7:0] cmdQ, cfgQ;
  logic       cmdHit, statHit, zeroCmd;
  logic [7:0] setBits, clrBits;

  assign cmdHit  = regWe && (regAddr == OFS_CMD);
  assign statHit = regWe && (regAddr == OFS_STAT);

  always_comb begin
    strb          = '0;
    strb.ldStart  = regWe && (regAddr == OFS_START);
    strb.ldStop   = regWe && (regAddr == OFS_STOP);
    strb.ldAddrLo = regWe && (regAddr == OFS_ADDRLO);
    strb.ldAddrHi = regWe && (regAddr == OFS_ADDRHI);
    strb.ldCntLo  = regWe && (regAddr == OFS_CNTLO);
    strb.ldCntHi  = regWe && (regAddr == OFS_CNTHI);
    strb.rd       = portRd;
    strb.memWr    = portWr && !cntZero;
    strb.step     = portRd || (portWr && !cntZero);
    strb.wide     = cfgQ[0];
  end

  // a go command (bit 0 low) with read or write requested and nothing to move
  assign zeroCmd = cmdHit && !regWdata[0] && (regWdata[3] || regWdata[4]) && cntZero;

  always_comb begin
    setBits = '0;
    clrBits = '0;
    setBits[STAT_DONE] = (strb.step && lastStep) || zeroCmd;
    if (statHit) clrBits = regWdata & 8'h7F;
    if (cmdHit && !regWdata[0]) clrBits[STAT_RST] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= '0;
      cfgQ    <= '0;
      maskQ   <= '0;
      statusQ <= 8'h80;
    end else begin
      if (cmdHit) cmdQ <= regWdata;
      if (regWe && (regAddr == OFS_CFG))  cfgQ  <= regWdata;
      if (regWe && (regAddr == OFS_MASK)) maskQ <= regWdata;
      statusQ <= (statusQ & ~clrBits) | setBits;
    end
  end

  assign irq = |(statusQ & maskQ & 8'h7F);

  always_comb begin
    unique case (regAddr)
      OFS_CMD:    regRdata = cmdQ;
      OFS_START:  regRdata = 8'(startPg);
      OFS_STOP:   regRdata = 8'(stopPg);
      OFS_ADDRLO: regRdata = addrQ[7:0];
      OFS_ADDRHI: regRdata = addrQ[15:8];
      OFS_CNTLO:  regRdata = cntQ[7:0];
      OFS_CNTHI:  regRdata = cntQ[15:8];
      OFS_STAT:   regRdata = statusQ;
      OFS_MASK:   regRdata = maskQ;
      OFS_CFG:    regRdata = cfgQ;
      default:    regRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rdma_dp.sv
module rdma_dp
  import rdma_pkg::*;
#(
  parameter int WIN_LO    = 'h400,
  parameter int WIN_BYTES = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdma_strobe_t      strb,
  input  logic [7:0]        regWdata,
  input  logic [15:0]       portWdata,
  output logic [ADDR_W-1:0] addrQ,
  output logic [ADDR_W-1:0] cntQ,
  output logic [PG_W-1:0]   startPg,
  output logic [PG_W-1:0]   stopPg,
  output logic              cntZero,
  output logic              lastStep,
  output logic [15:0]       portRdata
);
  localparam int WIN_HI     = WIN_LO + WIN_BYTES;
  localparam int LANE_DEPTH = WIN_BYTES / 2;
  localparam int IDX_W      = $clog2(WIN_BYTES);

  logic [ADDR_W-1:0] stepSize, addrStep, addrNext, memAddr;
  logic [IDX_W-1:0]  offs;
  logic [IDX_W-2:0]  laneIdx;
  logic              inWin, oddByte;
  logic [7:0]        laneRd [2];
  logic [15:0]       rdValue;

  assign stepSize = strb.wide ? ADDR_W'(2) : ADDR_W'(1);
  assign cntZero  = (cntQ == '0);
  assign lastStep = (cntQ <= stepSize);
  assign addrStep = addrQ + stepSize;
  assign addrNext = (addrStep == {stopPg, 8'h00}) ? {startPg, 8'h00} : addrStep;

  assign memAddr = strb.wide ? {addrQ[ADDR_W-1:1], 1'b0} : addrQ;
  assign inWin   = ({1'b0, memAddr} >= (ADDR_W+1)'(WIN_LO)) &&
                   ({1'b0, memAddr} <  (ADDR_W+1)'(WIN_HI));
  assign offs    = IDX_W'(memAddr - ADDR_W'(WIN_LO));
  assign laneIdx = offs[IDX_W-1:1];
  assign oddByte = offs[0];

  // even bytes in lane 0, odd bytes in lane 1; a word touches both at one index
  for (genvar lane = 0; lane < 2; lane++) begin : gLane
    logic [7:0] bank [LANE_DEPTH];
    logic       wrEn;
    logic [7:0] wrByte;
    assign wrEn   = strb.memWr && inWin && (strb.wide || (oddByte == lane[0]));
    assign wrByte = (lane == 1 && strb.wide) ? portWdata[15:8] : portWdata[7:0];
    always_ff @(posedge clk) begin
      if (wrEn) bank[laneIdx] <= wrByte;
    end
    assign laneRd[lane] = bank[laneIdx];
  end

  always_comb begin
    if (!inWin)          rdValue = strb.wide ? 16'hFFFF : 16'h00FF;
    else if (strb.wide)  rdValue = {laneRd[1], laneRd[0]};
    else                 rdValue = {8'h00, oddByte ? laneRd[1] : laneRd[0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      cntQ      <= '0;
      startPg   <= '0;
      stopPg    <= '0;
      portRdata <= '0;
    end else begin
      if (strb.rd) portRdata <= rdValue;
      if (strb.ldStart) startPg <= regWdata;
      if (strb.ldStop)  stopPg  <= regWdata;
      if (strb.step) begin
        addrQ <= addrNext;
        cntQ  <= lastStep ? '0 : cntQ - stepSize;
      end else begin
        if (strb.ldAddrLo) addrQ[7:0]  <= regWdata;
        if (strb.ldAddrHi) addrQ[15:8] <= regWdata;
        if (strb.ldCntLo)  cntQ[7:0]   <= regWdata;
        if (strb.ldCntHi)  cntQ[15:8]  <= regWdata;
      end
    end
  end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int WIN_LO    = 'h400,
  parameter int WIN_BYTES = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        portRd,
  input  logic        portWr,
  input  logic [15:0] portWdata,
  output logic [15:0] portRdata,
  output logic        irq
);
  rdma_strobe_t      strb;
  logic [ADDR_W-1:0] addrQ, cntQ;
  logic [PG_W-1:0]   startPg, stopPg;
  logic              cntZero, lastStep, wide;
  logic [7:0]        statusQ, maskQ;

  assign wide = strb.wide;

  rdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .portRd(portRd), .portWr(portWr), .cntZero(cntZero), .lastStep(lastStep),
    .addrQ(addrQ), .cntQ(cntQ), .startPg(startPg), .stopPg(stopPg),
    .strb(strb), .regRdata(regRdata), .statusQ(statusQ), .maskQ(maskQ), .irq(irq)
  );

  rdma_dp #(.WIN_LO(WIN_LO), .WIN_BYTES(WIN_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata), .portWdata(portWdata),
    .addrQ(addrQ), .cntQ(cntQ), .startPg(startPg), .stopPg(stopPg),
    .cntZero(cntZero), .lastStep(lastStep), .portRdata(portRdata)
  );
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic        portRd,
  input logic        portWr,
  input logic        irq,
  input logic        wide,
  input logic [15:0] addrQ,
  input logic [15:0] cntQ,
  input logic [7:0]  statusQ,
  input logic [7:0]  maskQ
);
  a_r3_byte_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && !regWe && !wide && cntQ > 16'd1) |=> (cntQ == $past(cntQ) - 16'd1));

  a_r4_word_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && !regWe && wide && cntQ > 16'd2) |=> (cntQ == $past(cntQ) - 16'd2));

  a_r6_final_step_flags: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && !regWe && cntQ != 16'd0 && cntQ <= (wide ? 16'd2 : 16'd1))
      |=> (statusQ[6] && cntQ == 16'd0));

  a_r7_idle_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && !regWe && cntQ == 16'd0) |=> ($stable(addrQ) && cntQ == 16'd0));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[6:0] == 7'd0) |-> !irq);

  a_r10_reset_flag_never_sets: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(statusQ[7]));

  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(portRd && portWr));
endmodule

bind rdma_port_engine rdma_port_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .portRd(portRd), .portWr(portWr),
  .irq(irq), .wide(wide), .addrQ(addrQ), .cntQ(cntQ), .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/rdma_port_engine_bench.sv
`timescale 1ns/1ps
module rdma_port_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        portRd = 1'b0;
  logic        portWr = 1'b0;
  logic [15:0] portWdata = '0;
  logic [15:0] portRdata;
  logic        irq;

  always #10 clk = ~clk;

  rdma_port_engine u_rdma_port_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .portRd(portRd), .portWr(portWr), .portWdata(portWdata),
    .portRdata(portRdata), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit live = 0;

  // behavioural reference state
  logic [15:0] mAddr = 0, mCnt = 0, mRdata = 0;
  logic [7:0]  mStart = 0, mStop = 0, mIsr = 8'h80, mImr = 0, mCfg = 0, mCmd = 0;
  logic [7:0]  mMem [int];

  function automatic bit mIrq();
    return (mIsr & mImr & 8'h7F) != 0;
  endfunction

  function automatic bit inWin(int a);
    return a >= 'h400 && a < 'h600;
  endfunction

  function automatic int stepSz();
    return mCfg[0] ? 2 : 1;
  endfunction

  function automatic void mAdvance();
    int sz = stepSz();
    mAddr = mAddr + 16'(sz);
    if (mAddr == {mStop, 8'h00}) mAddr = {mStart, 8'h00};
    if (int'(mCnt) <= sz) begin mCnt = 0; mIsr[6] = 1'b1; end
    else mCnt = mCnt - 16'(sz);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !finished) begin
      chk("R9 irq", int'(irq), int'(mIrq()));
      chk("R12 portRdata", int'(portRdata), int'(mRdata));
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    case (a)
      4'd0: begin
        mCmd = d;
        if (!d[0]) begin
          mIsr[7] = 1'b0;
          if ((d[3] || d[4]) && mCnt == 0) mIsr[6] = 1'b1;
        end
      end
      4'd1: mStart = d;
      4'd2: mStop = d;
      4'd3: mAddr[7:0] = d;
      4'd4: mAddr[15:8] = d;
      4'd5: mCnt[7:0] = d;
      4'd6: mCnt[15:8] = d;
      4'd7: mIsr = mIsr & ~(d & 8'h7F);
      4'd8: mImr = d;
      4'd9: mCfg = d;
      default: ;
    endcase
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic portWrite(input logic [15:0] d);
    @(negedge clk);
    portWr = 1; portWdata = d;
    @(posedge clk); #1;
    if (mCnt != 0) begin
      int a = mCfg[0] ? int'(mAddr & 16'hFFFE) : int'(mAddr);
      if (inWin(a)) begin
        mMem[a] = d[7:0];
        if (mCfg[0]) mMem[a+1] = d[15:8];
      end
      mAdvance();
    end
    @(negedge clk);
    portWr = 0;
  endtask

  task automatic portRead(string req, input logic [15:0] exp);
    int a;
    @(negedge clk);
    portRd = 1;
    @(posedge clk); #1;
    a = mCfg[0] ? int'(mAddr & 16'hFFFE) : int'(mAddr);
    if (mCfg[0]) mRdata = inWin(a) ? {mMem[a+1], mMem[a]} : 16'hFFFF;
    else         mRdata = inWin(a) ? {8'h00, mMem[a]} : 16'h00FF;
    mAdvance();
    @(negedge clk);
    portRd = 0;
    chk(req, int'(portRdata), int'(exp));
  endtask

  task automatic chkReg(string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, int'(regRdata), int'(exp));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    live = 1;
    // R1 reset state
    chkReg("R1 status", 4'd7, 8'h80);
    chkReg("R1 addrLo", 4'd3, 8'h00);
    chkReg("R1 cntHi", 4'd6, 8'h00);
    chkReg("R1 mask", 4'd8, 8'h00);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rdata", int'(portRdata), 0);
    // R9 bit 7 cannot interrupt, R10 bit 7 survives W1C
    wrReg(4'd8, 8'hFF);
    chk("R9 bit7 masked out", int'(irq), 0);
    wrReg(4'd7, 8'hFF);
    chkReg("R10 bit7 kept", 4'd7, 8'h80);
    wrReg(4'd8, 8'h40);
    // ring 0x0400..0x0600, byte mode
    wrReg(4'd1, 8'h04);
    wrReg(4'd2, 8'h06);
    wrReg(4'd9, 8'h00);
    wrReg(4'd3, 8'hFE);
    wrReg(4'd4, 8'h05);
    wrReg(4'd5, 8'h04);
    wrReg(4'd6, 8'h00);
    chkReg("R2 addrHi", 4'd4, 8'h05);
    chkReg("R2 addrLo", 4'd3, 8'hFE);
    chkReg("R2 cntLo", 4'd5, 8'h04);
    chkReg("R2 startPg", 4'd1, 8'h04);
    chkReg("R2 unused", 4'd12, 8'h00);
    // R8 start write with nonzero count: clears bit7, no completion
    wrReg(4'd0, 8'h12);
    chkReg("R8 nonzero count", 4'd7, 8'h00);
    portWrite(16'h00AA);
    portWrite(16'h00BB);
    chkReg("R5 wrap addrHi", 4'd4, 8'h04);
    chkReg("R5 wrap addrLo", 4'd3, 8'h00);
    chkReg("R3 count step", 4'd5, 8'h02);
    portWrite(16'h00CC);
    portWrite(16'h00EE);
    chkReg("R6 count zero", 4'd5, 8'h00);
    chkReg("R6 done flag", 4'd7, 8'h40);
    chk("R9 irq high", int'(irq), 1);
    // R7 write with zero count is dropped
    wrReg(4'd3, 8'h00);
    portWrite(16'h0077);
    chkReg("R7 addr unchanged", 4'd3, 8'h00);
    chkReg("R7 count unchanged", 4'd5, 8'h00);
    // R10 clear
    wrReg(4'd7, 8'hFF);
    chkReg("R10 cleared", 4'd7, 8'h00);
    chk("R10 irq low", int'(irq), 0);
    // R8 zero-length read command
    wrReg(4'd0, 8'h0A);
    chkReg("R8 zero length", 4'd7, 8'h40);
    wrReg(4'd7, 8'h40);
    // R7/R3 read back byte at 0x0400, still CC
    wrReg(4'd5, 8'h02);
    portRead("R7 memory kept", 16'h00CC);
    portRead("R3 byte read", 16'h00EE);
    wrReg(4'd7, 8'h40);
    // R4 word mode at odd address 0x05FF
    wrReg(4'd9, 8'h01);
    wrReg(4'd3, 8'hFF);
    wrReg(4'd4, 8'h05);
    wrReg(4'd5, 8'h04);
    portRead("R4 word little endian", 16'hBBAA);
    chkReg("R4 addr plus two", 4'd3, 8'h01);
    chkReg("R4 count minus two", 4'd5, 8'h02);
    portRead("R11 word outside", 16'hFFFF);
    chkReg("R6 word done", 4'd7, 8'h40);
    wrReg(4'd7, 8'h40);
    // R4 word write, then byte readback
    wrReg(4'd3, 8'h10);
    wrReg(4'd4, 8'h04);
    wrReg(4'd5, 8'h02);
    portWrite(16'h1234);
    wrReg(4'd9, 8'h00);
    wrReg(4'd3, 8'h10);
    wrReg(4'd5, 8'h02);
    portRead("R4 low byte first", 16'h0034);
    portRead("R4 high byte second", 16'h0012);
    // R11 byte read below window
    wrReg(4'd3, 8'h00);
    wrReg(4'd4, 8'h01);
    wrReg(4'd5, 8'h01);
    portRead("R11 byte outside", 16'h00FF);
    repeat (3) @(negedge clk);
    chk("R12 rdata held", int'(portRdata), 16'h00FF);
    summary();
  end
endmodule